// File: doc/BRIEF.md
# Flow-Controlled Network DMA Engine

This block pairs two DMA channels between a shared memory bus and a network interface. The send channel fetches a message from memory one word per bus beat and pushes each word into the interface's outbound queue. The receive channel pops words from the interface's inbound queue and stores them to memory. Each channel is armed by a one-cycle start strobe, a byte address that is forced to word alignment, and a length in words. It reports completion on a level done flag that stays high until the next start.

The two channels share one bus master port with a request/grant handshake. They take turns round-robin, and each ownership lasts at most one burst of `BURST` words. The outbound queue reports its free space in words. When that space reaches zero, hardware flow control stalls the send channel, and the channel withdraws its bus request so the receive side, or any other master, can use the bus. The send channel does not ask for the bus again until a whole burst of room is free. The receive channel waits, losing no data, whenever the inbound queue runs empty before its count is reached.

Top module: `ni_dma_engine`

## Requirements
- R1: After reset, bus_req_o, txq_wr_o, rxq_rd_o, tx_done_o and rx_done_o are all low.
- R2: A send job moves exactly len words from ascending word addresses starting at the start address (step 4 bytes) into the outbound queue, in order. tx_done_o rises after the last word and holds until the next start.
- R3: A receive job stores exactly len queue words, in pop order, at ascending word addresses starting at the start address, and leaves the word just past the end untouched. rx_done_o rises after the last word.
- R4: No word is written to the outbound queue in a cycle where txq_free_i is 0. While the send channel is blocked this way and the receive channel is idle, bus_req_o is low.
- R5: Once txq_free_i has been 0, no further send beat occurs until txq_free_i is at least BURST (8). A free count of exactly 8 releases the stall.
- R6: rxq_rd_o is never high while rxq_empty_i is high. A receive job that runs out of queue data waits with rx_done_o low, writes nothing past the data received, and completes once the data arrives.
- R7: A transfer beat (txq_wr_o or rxq_rd_o high) happens only in a cycle with bus_req_o and bus_gnt_i both high, and at most one channel moves a word per cycle.
- R8: No more than BURST (8) beats occur in consecutive cycles. Each ownership ends with at least one cycle in which there is no beat.
- R9: While both channels have work and are able to move data, successive bursts alternate between the send and receive channels.
- R10: A start with length 0 raises that channel's done flag on the next clock edge, with no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_start_i | input | 1 | Send job start strobe (ignored while busy) |
| tx_addr_i | input | AW | Send job start byte address (low two bits ignored) |
| tx_len_i | input | LENW | Send job length in words |
| tx_done_o | output | 1 | Send job complete |
| rx_start_i | input | 1 | Receive job start strobe (ignored while busy) |
| rx_addr_i | input | AW | Receive job start byte address (low two bits ignored) |
| rx_len_i | input | LENW | Receive job length in words |
| rx_done_o | output | 1 | Receive job complete |
| bus_req_o | output | 1 | Bus request; a beat completes in any cycle it is high together with grant |
| bus_gnt_i | input | 1 | Bus grant |
| bus_we_o | output | 1 | 1 = write (receive channel owns the bus), 0 = read |
| bus_addr_o | output | AW | Bus byte address |
| bus_wdata_o | output | DW | Bus write data |
| bus_rdata_i | input | DW | Bus read data, valid in the cycle of the beat |
| txq_wr_o | output | 1 | Push a word into the outbound queue |
| txq_wdata_o | output | DW | Word pushed into the outbound queue |
| txq_free_i | input | QCW | Free words in the outbound queue |
| rxq_rd_o | output | 1 | Pop a word from the inbound queue |
| rxq_rdata_i | input | DW | Head word of the inbound queue |
| rxq_empty_i | input | 1 | Inbound queue empty |

## Verification
Send and receive jobs are tried with three grant patterns: grant always high, grant every other cycle, and grant withheld one cycle in four. Comparing them shows whether beats follow the grant rather than the request. Receive jobs run both with the queue preloaded and with it starved partway through, which separates a correct wait from dropped or invented words. The send stall is driven through free counts of 3, 0, 5, 8 and ample. The counts of 5 and 8 separate a restart rule based on a full burst of room from one based on any room at all. A concurrent job of 24 words on each side exposes the burst length and the alternation order.

// File: rtl/ni_dma_pkg.sv
package ni_dma_pkg;
  typedef enum logic [1:0] {
    OWN_IDLE = 2'd0,
    OWN_TX   = 2'd1,
    OWN_RX   = 2'd2
  } owner_e;
endpackage

// File: rtl/ni_dma_chan.sv
// Descriptor address/count tracker shared by both directions.
module ni_dma_chan #(
  parameter int AW   = 32,
  parameter int LENW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [LENW-1:0] len_i,
  input  logic            avail_i,
  input  logic            beat_i,
  output logic            rdy_o,
  output logic [AW-1:0]   addr_o,
  output logic            done_o
);
  logic [AW-1:0]   addr_q;
  logic [LENW-1:0] rem_q;
  logic            done_q;
  logic            busy;

  assign busy   = (rem_q != '0);
  assign rdy_o  = busy && avail_i;
  assign addr_o = addr_q;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      rem_q  <= '0;
      done_q <= 1'b0;
    end else if (start_i && !busy) begin
      addr_q <= {addr_i[AW-1:2], 2'b00};
      rem_q  <= len_i;
      done_q <= (len_i == '0);
    end else if (beat_i) begin
      addr_q <= addr_q + AW'(4);
      rem_q  <= rem_q - LENW'(1);
      if (rem_q == LENW'(1)) done_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ni_dma_txfc.sv
// Outbound flow control: block on full, resume only with a burst of room.
module ni_dma_txfc #(
  parameter int BURST = 8,
  parameter int QCW   = 10
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [QCW-1:0] free_i,
  output logic           ok_o
);
  localparam logic [QCW-1:0] ROOM = QCW'(BURST);
  logic stall_q;

  assign ok_o = !stall_q && (free_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               stall_q <= 1'b0;
    else if (free_i == '0)     stall_q <= 1'b1;
    else if (free_i >= ROOM)   stall_q <= 1'b0;
  end
endmodule

// File: rtl/ni_dma_arb.sv
// Round-robin bus owner with burst cap; request drops the moment the owner cannot move.
module ni_dma_arb import ni_dma_pkg::*; #(
  parameter int BURST = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_rdy_i,
  input  logic rx_rdy_i,
  input  logic gnt_i,
  output logic req_o,
  output logic sel_rx_o,
  output logic tx_beat_o,
  output logic rx_beat_o
);
  localparam int BCW = (BURST > 1) ? $clog2(BURST) : 1;
  localparam logic [BCW-1:0] LAST = BCW'(BURST - 1);

  owner_e         own_q;
  logic           last_rx_q;
  logic [BCW-1:0] cnt_q;
  logic           own_rdy, beat, burst_end;

  always_comb begin
    own_rdy   = (own_q == OWN_TX && tx_rdy_i) || (own_q == OWN_RX && rx_rdy_i);
    beat      = own_rdy && gnt_i;
    burst_end = !own_rdy || (beat && cnt_q == LAST);
  end

  assign req_o     = own_rdy;
  assign sel_rx_o  = (own_q == OWN_RX);
  assign tx_beat_o = beat && (own_q == OWN_TX);
  assign rx_beat_o = beat && (own_q == OWN_RX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q     <= OWN_IDLE;
      last_rx_q <= 1'b1;
      cnt_q     <= '0;
    end else begin
      case (own_q)
        OWN_IDLE: begin
          cnt_q <= '0;
          if (tx_rdy_i && rx_rdy_i) own_q <= last_rx_q ? OWN_TX : OWN_RX;
          else if (tx_rdy_i)        own_q <= OWN_TX;
          else if (rx_rdy_i)        own_q <= OWN_RX;
        end
        default: begin
          if (burst_end) begin
            own_q     <= OWN_IDLE;
            last_rx_q <= (own_q == OWN_RX);
            cnt_q     <= '0;
          end else if (beat) begin
            cnt_q <= cnt_q + BCW'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ni_dma_engine.sv
module ni_dma_engine #(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int LENW   = 16,
  parameter int BURST  = 8,
  parameter int QWORDS = 512,
  parameter int QCW    = $clog2(QWORDS + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tx_start_i,
  input  logic [AW-1:0]   tx_addr_i,
  input  logic [LENW-1:0] tx_len_i,
  output logic            tx_done_o,
  input  logic            rx_start_i,
  input  logic [AW-1:0]   rx_addr_i,
  input  logic [LENW-1:0] rx_len_i,
  output logic            rx_done_o,
  output logic            bus_req_o,
  input  logic            bus_gnt_i,
  output logic            bus_we_o,
  output logic [AW-1:0]   bus_addr_o,
  output logic [DW-1:0]   bus_wdata_o,
  input  logic [DW-1:0]   bus_rdata_i,
  output logic            txq_wr_o,
  output logic [DW-1:0]   txq_wdata_o,
  input  logic [QCW-1:0]  txq_free_i,
  output logic            rxq_rd_o,
  input  logic [DW-1:0]   rxq_rdata_i,
  input  logic            rxq_empty_i
);
  logic          tx_ok, tx_rdy, rx_rdy, tx_beat, rx_beat, sel_rx;
  logic [AW-1:0] tx_addr, rx_addr;

  ni_dma_txfc #(.BURST(BURST), .QCW(QCW)) u_txfc (
    .clk_i(clk_i), .rst_ni(rst_ni), .free_i(txq_free_i), .ok_o(tx_ok)
  );

  ni_dma_chan #(.AW(AW), .LENW(LENW)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(tx_start_i), .addr_i(tx_addr_i),
    .len_i(tx_len_i), .avail_i(tx_ok), .beat_i(tx_beat), .rdy_o(tx_rdy),
    .addr_o(tx_addr), .done_o(tx_done_o)
  );

  ni_dma_chan #(.AW(AW), .LENW(LENW)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(rx_start_i), .addr_i(rx_addr_i),
    .len_i(rx_len_i), .avail_i(!rxq_empty_i), .beat_i(rx_beat), .rdy_o(rx_rdy),
    .addr_o(rx_addr), .done_o(rx_done_o)
  );

  ni_dma_arb #(.BURST(BURST)) u_arb (
    .clk_i(clk_i), .rst_ni(rst_ni), .tx_rdy_i(tx_rdy), .rx_rdy_i(rx_rdy),
    .gnt_i(bus_gnt_i), .req_o(bus_req_o), .sel_rx_o(sel_rx),
    .tx_beat_o(tx_beat), .rx_beat_o(rx_beat)
  );

  assign bus_we_o    = sel_rx;
  assign bus_addr_o  = sel_rx ? rx_addr : tx_addr;
  assign bus_wdata_o = rxq_rdata_i;
  assign txq_wr_o    = tx_beat;
  assign txq_wdata_o = bus_rdata_i;
  assign rxq_rd_o    = rx_beat;
endmodule

// File: rtl/ni_dma_engine_chk.sv
module ni_dma_engine_chk #(
  parameter int BURST  = 8,
  parameter int QWORDS = 512,
  parameter int QCW    = $clog2(QWORDS + 1)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           tx_start_i,
  input logic           tx_done_o,
  input logic           txq_wr_o,
  input logic [QCW-1:0] txq_free_i,
  input logic           rxq_rd_o,
  input logic           rxq_empty_i,
  input logic           bus_req_o,
  input logic           bus_gnt_i
);
  logic        seen_full_q;
  logic [15:0] run_q;
  logic        beat;

  assign beat = txq_wr_o || rxq_rd_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_full_q <= 1'b0;
      run_q       <= '0;
    end else begin
      if (txq_free_i == '0)              seen_full_q <= 1'b1;
      else if (txq_free_i >= QCW'(BURST)) seen_full_q <= 1'b0;
      run_q <= beat ? ((run_q == 16'hFFFF) ? run_q : run_q + 16'd1) : 16'd0;
    end
  end

  p_no_full_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txq_wr_o |-> (txq_free_i != '0));
  p_resume_room_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txq_wr_o |-> !seen_full_q);
  p_no_empty_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxq_rd_o |-> !rxq_empty_i);
  p_beat_granted_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat |-> (bus_req_o && bus_gnt_i));
  p_single_beat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(txq_wr_o && rxq_rd_o));
  p_burst_cap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    beat |-> (run_q < 16'(BURST)));
  p_done_holds_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_o && !tx_start_i) |=> tx_done_o);
endmodule

bind ni_dma_engine ni_dma_engine_chk #(.BURST(BURST), .QWORDS(QWORDS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tx_start_i(tx_start_i), .tx_done_o(tx_done_o),
  .txq_wr_o(txq_wr_o), .txq_free_i(txq_free_i), .rxq_rd_o(rxq_rd_o),
  .rxq_empty_i(rxq_empty_i), .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt_i)
);

// File: tb/ni_dma_engine_tb_top.sv
`timescale 1ns/1ps
module ni_dma_engine_tb_top;
  localparam int CAP = 512;
  localparam int QCW = 10;

  typedef struct packed {
    logic       is_rx;
    logic [7:0] widx;
    logic [7:0] len;
    logic [1:0] gm;
    logic [7:0] pre;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd0,   8'd5,  2'd0, 8'd0},
    '{1'b0, 8'd16,  8'd17, 2'd1, 8'd0},
    '{1'b0, 8'd40,  8'd8,  2'd2, 8'd0},
    '{1'b1, 8'd128, 8'd6,  2'd0, 8'd6},
    '{1'b1, 8'd150, 8'd20, 2'd1, 8'd4},
    '{1'b1, 8'd200, 8'd9,  2'd2, 8'd9},
    '{1'b0, 8'd100, 8'd1,  2'd0, 8'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        tx_start = 0, rx_start = 0;
  logic [31:0] tx_addr = 0, rx_addr = 0;
  logic [15:0] tx_len = 0, rx_len = 0;
  logic        tx_done, rx_done, bus_req, bus_gnt, bus_we, txq_wr, rxq_rd, rxq_empty;
  logic [31:0] bus_addr, bus_wdata, bus_rdata, txq_wdata, rxq_rdata;
  logic [QCW-1:0] txq_free;

  ni_dma_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_start_i(tx_start), .tx_addr_i(tx_addr), .tx_len_i(tx_len), .tx_done_o(tx_done),
    .rx_start_i(rx_start), .rx_addr_i(rx_addr), .rx_len_i(rx_len), .rx_done_o(rx_done),
    .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_rdata_i(bus_rdata),
    .txq_wr_o(txq_wr), .txq_wdata_o(txq_wdata), .txq_free_i(txq_free),
    .rxq_rd_o(rxq_rd), .rxq_rdata_i(rxq_rdata), .rxq_empty_i(rxq_empty)
  );

  function automatic logic [31:0] minit(int i);
    return (32'(i) * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction
  function automatic logic [31:0] rxw(int k);
    return 32'hB00D0000 + 32'(k);
  endfunction

  // memory model
  logic [31:0] mem [256];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= minit(i);
    end else if (bus_req && bus_gnt && bus_we) begin
      mem[bus_addr[9:2]] <= bus_wdata;
    end
  end
  assign bus_rdata = mem[bus_addr[9:2]];

  // grant pattern
  int          gmode = 0;
  logic [31:0] cyc = 0;
  always @(negedge clk) cyc <= cyc + 1;
  assign bus_gnt = (gmode == 0) ? 1'b1 : (gmode == 1) ? cyc[0] : (cyc[1:0] != 2'd0);

  // outbound queue model
  logic [31:0] txlog [256];
  int txn = 0, occ = 0, occ_val = 0;
  logic occ_force = 0;
  always @(posedge clk) begin
    if (txq_wr) begin
      txlog[txn % 256] <= txq_wdata;
      txn <= txn + 1;
    end
    if (occ_force) occ <= occ_val;
    else if (txq_wr) occ <= occ + 1;
  end
  assign txq_free = QCW'(CAP - occ);

  // inbound queue model
  logic [31:0] rxq [64];
  int rp = 0, wp = 0;
  always @(posedge clk) if (rxq_rd) rp <= rp + 1;
  assign rxq_empty = (rp == wp);
  assign rxq_rdata = rxq[rp % 64];

  // burst monitor
  logic mon_en = 0, prev_beat = 0, last_we = 0, have_last = 0;
  int run = 0, max_run = 0, viol = 0, nb = 0;
  always @(posedge clk) begin
    prev_beat <= bus_req && bus_gnt;
    if (mon_en && bus_req && bus_gnt) begin
      if (prev_beat) begin
        run <= run + 1;
        if (run + 1 > max_run) max_run <= run + 1;
      end else begin
        run <= 1;
        if (max_run < 1) max_run <= 1;
        if (!tx_done && !rx_done) begin
          if (have_last && last_we == bus_we) viol <= viol + 1;
          last_we <= bus_we;
          have_last <= 1'b1;
          nb <= nb + 1;
        end
      end
    end
  end

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd == 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 0);
      finish_run();
    end
  end

  task automatic push(input int n);
    for (int k = 0; k < n; k++) begin
      rxq[wp % 64] = rxw(wp);
      wp = wp + 1;
    end
  endtask

  task automatic start_tx(input int widx, input int len);
    @(negedge clk);
    tx_addr = 32'(widx * 4); tx_len = 16'(len); tx_start = 1;
    @(negedge clk);
    tx_start = 0;
  endtask

  task automatic start_rx(input int widx, input int len);
    @(negedge clk);
    rx_addr = 32'(widx * 4); rx_len = 16'(len); rx_start = 1;
    @(negedge clk);
    rx_start = 0;
  endtask

  task automatic set_occ(input int v);
    @(negedge clk);
    occ_val = v; occ_force = 1;
    @(negedge clk);
    occ_force = 0;
  endtask

  task automatic wait_done(input bit is_rx);
    for (int t = 0; t < 3000; t++) begin
      @(negedge clk);
      if (is_rx ? rx_done : tx_done) break;
    end
  endtask

  task automatic check_tx_data(input int base, input int widx, input int len, input string rq);
    int mm = 0;
    for (int k = 0; k < len; k++)
      if (txlog[(base + k) % 256] !== minit(widx + k)) mm++;
    chk(mm == 0, rq, "send data mismatches", mm, 0);
  endtask

  task automatic check_rx_data(input int first, input int widx, input int len, input string rq);
    int mm = 0;
    for (int k = 0; k < len; k++)
      if (mem[widx + k] !== rxw(first + k)) mm++;
    chk(mm == 0, rq, "receive data mismatches", mm, 0);
  endtask

  task automatic run_vec(input vec_t v);
    int base, first;
    gmode = int'(v.gm);
    if (v.is_rx) begin
      first = wp;
      push(int'(v.pre));
      start_rx(int'(v.widx), int'(v.len));
      if (v.pre < v.len) begin
        repeat (30) @(negedge clk);
        chk(!rx_done, "R6", "done while starved", rx_done, 0);
        chk(mem[v.widx + v.pre] == minit(v.widx + v.pre), "R6", "word past data",
            mem[v.widx + v.pre], minit(v.widx + v.pre));
        push(int'(v.len - v.pre));
      end
      wait_done(1'b1);
      chk(rx_done, "R3", "rx done", rx_done, 1);
      check_rx_data(first, int'(v.widx), int'(v.len), "R3");
      chk(mem[v.widx + v.len] == minit(v.widx + v.len), "R3", "word after end",
          mem[v.widx + v.len], minit(v.widx + v.len));
      chk(rp == wp, "R6", "queue drained", rp, wp);
    end else begin
      base = txn;
      start_tx(int'(v.widx), int'(v.len));
      wait_done(1'b0);
      chk(tx_done, "R2", "tx done", tx_done, 1);
      chk(txn - base == int'(v.len), "R2", "send word count", txn - base, v.len);
      check_tx_data(base, int'(v.widx), int'(v.len), "R2");
      @(negedge clk);
      chk(tx_done, "R2", "tx done holds", tx_done, 1);
    end
    gmode = 0;
  endtask

  initial begin
    int base, first;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!bus_req, "R1", "bus_req after reset", bus_req, 0);
    chk(!txq_wr && !rxq_rd, "R1", "queue strobes after reset", {txq_wr, rxq_rd}, 0);
    chk(!tx_done, "R1", "tx_done after reset", tx_done, 0);
    chk(!rx_done, "R1", "rx_done after reset", rx_done, 0);

    // R10 zero length
    start_tx(5, 0);
    chk(tx_done, "R10", "done after zero-length start", tx_done, 1);
    chk(txn == 0, "R10", "words moved for zero length", txn, 0);
    chk(!bus_req, "R10", "bus_req for zero length", bus_req, 0);

    // vector table: R2, R3, R6, R7
    for (int v = 0; v < NV; v++) run_vec(VECS[v]);

    // R4/R5 flow-control stall and release
    set_occ(CAP - 3);
    base = txn;
    start_tx(60, 20);
    repeat (30) @(negedge clk);
    chk(txn - base == 3, "R4", "words before full", txn - base, 3);
    chk(!bus_req, "R4", "bus released while full", bus_req, 0);
    chk(!tx_done, "R4", "done while stalled", tx_done, 0);
    set_occ(CAP - 5);
    repeat (20) @(negedge clk);
    chk(txn - base == 3, "R5", "no restart with 5 free", txn - base, 3);
    chk(!bus_req, "R5", "no request with 5 free", bus_req, 0);
    set_occ(CAP - 8);
    repeat (20) @(negedge clk);
    chk(txn - base == 11, "R5", "restart with exactly 8 free", txn - base, 11);
    set_occ(0);
    wait_done(1'b0);
    chk(tx_done && txn - base == 20, "R5", "stalled job completes", txn - base, 20);
    check_tx_data(base, 60, 20, "R5");

    // R8/R9 concurrent jobs
    first = wp;
    push(24);
    base = txn;
    mon_en = 1;
    @(negedge clk);
    tx_addr = 32'(70 * 4); tx_len = 16'd24; tx_start = 1;
    rx_addr = 32'(220 * 4); rx_len = 16'd24; rx_start = 1;
    @(negedge clk);
    tx_start = 0; rx_start = 0;
    wait_done(1'b0);
    wait_done(1'b1);
    mon_en = 0;
    chk(max_run == 8, "R8", "longest beat run", max_run, 8);
    chk(viol == 0, "R9", "same-owner back-to-back bursts", viol, 0);
    chk(nb >= 4, "R9", "bursts while both pending", nb, 4);
    chk(tx_done && rx_done, "R9", "both done", {tx_done, rx_done}, 3);
    check_tx_data(base, 70, 24, "R9");
    check_rx_data(first, 220, 24, "R9");

    finish_run();
  end
endmodule